// File: doc/BRIEF.md
# Periodic Interval Timer with Interrupt Flag and Enable Registers

This block is a 16-bit down-counter that reloads itself from a pair of byte latches and raises an interrupt each time it runs past zero. Software programs the low latch byte, then writes the high byte. That second write arms the counter and starts it. In free-run mode the block then produces a steady stream of interrupt requests with no further writes, which suits a periodic tick such as the refresh of a multiplexed display.

Alongside the timer sit a seven-bit interrupt flag register and a matching enable register. Bit 6 of both belongs to the timer. Bits 5 to 0 are flags that neighbouring sources set through pulse inputs. The enable register is written with a set/clear convention carried in bit 7. The active-low interrupt output is asserted whenever any flag is set and also enabled. The interrupt service routine clears the timer flag by reading the low counter byte.

Top module: `itmr_top`

## Requirements
- R1: After reset the counter is zero and stopped, all flags and enables are zero, the mode register reads 00h and `irq_n` is high.
- R2: A write to address 0 loads only the low latch byte. The counter and the flags are unchanged. The low latch reads back at address 2.
- R3: A write to address 1 does four things: it loads the high latch byte, copies both latch bytes into the counter, clears flag bit 6 and starts counting down from the next clock.
- R4: With mode register bits 7:6 = 01 (free-run), the counter passes from zero to FFFFh. On that same edge it sets flag bit 6. On the following edge it reloads from the latches. Flag bit 6 therefore sets N+1 clocks after the starting write and every N+2 clocks after that, where N is the latch value.
- R5: With any other value in mode bits 7:6, the counter keeps decrementing and wraps modulo 2^16. It neither reloads nor sets flag bit 6.
- R6: A write to the enable register (address 6) with bit 7 = 1 sets every enable bit whose position in bits 6:0 is written as 1. All other enable bits keep their state.
- R7: A write to the enable register with bit 7 = 0 clears every enable bit whose position in bits 6:0 is written as 1. All other enable bits keep their state. The enable register reads back with bit 7 = 1.
- R8: A read of address 0 clears flag bit 6. A read of address 1 leaves the flags unchanged.
- R9: The flag register (address 5) reads the flags in bits 6:0. Bit 7 reads as the OR of all flags that are both set and enabled. `irq_n` is low exactly when that bit is 1.
- R10: A one-cycle pulse on `ext_set[i]` sets flag bit i. A write to address 5 clears each flag written as 1.
- R11: A write to address 3 loads only the high latch byte. It does not load or start the counter. Addresses 2 and 3 read back the latch bytes.
- R12: Addresses 0 and 1 read the live counter low and high bytes. Address 4 reads back the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 1 | Bus access strobe, one cycle per access |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid combinationally during the access cycle |
| ext_set | input | 6 | Set pulses for flag bits 5:0 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
If the counter or the wrap state goes wrong, the interrupt edge lands in the wrong clock. The bench therefore times `irq_n` to the exact cycle, both after the starting write and across one full reload period. A stale reload value shows at once in the counter byte read on the cycle that follows the wrap. Faults in the flag clear paths or in the enable set/clear decoding appear on the very next read of the flag or enable register. They also appear as `irq_n` remaining low, or failing to fall, one cycle after the access.

// File: rtl/itmr_pkg.sv
// Package: shared widths, register addresses and mode encoding for the
// interval timer. Assumes byte-wide bus accesses and a two-byte counter.
package itmr_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int NUM_IRQ  = BYTE_W - 1;
    localparam int TMR_IRQ  = NUM_IRQ - 1;
    localparam int ADDR_W   = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CNT_LO = 3'd0,
        A_CNT_HI = 3'd1,
        A_LAT_LO = 3'd2,
        A_LAT_HI = 3'd3,
        A_MODE   = 3'd4,
        A_FLAG   = 3'd5,
        A_ENAB   = 3'd6
    } reg_addr_e;

    localparam logic [1:0] MODE_FREE_RUN = 2'b01;
endpackage

// File: rtl/itmr_counter.sv
// Module: itmr_counter
// Down-counter with two byte latches. A start strobe loads the high latch and
// copies both latches into the counter. In free-run mode the counter passes
// zero to all-ones, pulses tick, then reloads on the next clock.
// Assumes start and latch writes are single-cycle strobes.
module itmr_counter
    import itmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_lo_we,
    input  logic              lat_hi_we,
    input  logic              start,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              free_run,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  latch,
    output logic              tick
);
    logic [BYTE_W-1:0] lat_lo;
    logic [BYTE_W-1:0] lat_hi;
    logic              running;
    logic              wrapped;

    assign latch = {lat_hi, lat_lo};

    // The zero crossing is reported only in free-run mode, on the edge that leaves zero.
    assign tick = running && !start && free_run && !wrapped && (cnt == '0);

    // Latch registers: low byte from its own write, high byte from either high write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_lo <= '0;
            lat_hi <= '0;
        end else begin
            if (lat_lo_we)
                lat_lo <= wdata;
            if (lat_hi_we || start)
                lat_hi <= wdata;
        end
    end

    // Counter: load on start, reload after the wrap in free-run, else decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
            wrapped <= 1'b0;
        end else if (start) begin
            cnt     <= {wdata, lat_lo};
            running <= 1'b1;
            wrapped <= 1'b0;
        end else if (running) begin
            if (free_run && wrapped) begin
                cnt     <= latch;
                wrapped <= 1'b0;
            end else begin
                cnt     <= cnt - 1'b1;
                wrapped <= free_run && (cnt == '0);
            end
        end
    end

    // The start write puts the written byte into the counter's high half.
    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt[CNT_W-1:BYTE_W] == $past(wdata)) && running);

    // In free-run, the cycle after the wrap brings back the latch value.
    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && free_run && wrapped && !start) |=> cnt == $past(latch));

    // Outside free-run the counter only ever steps down by one.
    p_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !free_run && !start) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/itmr_irq.sv
// Module: itmr_irq
// Interrupt flag and enable registers. Each flag sets on its source pulse and
// clears on its clear request, with set taking priority. Enables are written
// with a set/clear convention selected by the top bit of the write data.
module itmr_irq
    import itmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tmr_set,
    input  logic               tmr_clr,
    input  logic [NUM_IRQ-2:0] ext_set,
    input  logic               flag_we,
    input  logic               en_we,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [NUM_IRQ-1:0] flags,
    output logic [NUM_IRQ-1:0] enables,
    output logic               irq_any
);
    logic [NUM_IRQ-1:0] set_v;
    logic [NUM_IRQ-1:0] clr_v;

    // Gather the per-bit set and clear requests.
    always_comb begin
        set_v = {tmr_set, ext_set};
        clr_v = flag_we ? wdata[NUM_IRQ-1:0] : '0;
        clr_v[TMR_IRQ] = clr_v[TMR_IRQ] | tmr_clr;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_flag
        // One flag bit: set wins over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[i] <= 1'b0;
            else
                flags[i] <= set_v[i] | (flags[i] & ~clr_v[i]);
        end
    end

    // Enable register: bit 7 of the write selects set or clear of the marked bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enables <= '0;
        else if (en_we) begin
            if (wdata[BYTE_W-1])
                enables <= enables | wdata[NUM_IRQ-1:0];
            else
                enables <= enables & ~wdata[NUM_IRQ-1:0];
        end
    end

    assign irq_any = |(flags & enables);

    p_tick_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_set |=> flags[TMR_IRQ]);

    p_clear_timer_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_clr && !tmr_set) |=> !flags[TMR_IRQ]);

    p_enable_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && wdata[BYTE_W-1]) |=>
            ((enables & $past(wdata[NUM_IRQ-1:0])) == $past(wdata[NUM_IRQ-1:0])));

    p_enable_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && !wdata[BYTE_W-1]) |=> ((enables & $past(wdata[NUM_IRQ-1:0])) == '0));
endmodule

// File: rtl/itmr_bus.sv
// Module: itmr_bus
// Register decode for the timer. It produces single-cycle write strobes and
// the read side-effect strobe, holds the mode register and drives the
// combinational read mux. Assumes sel is high for one cycle per access.
module itmr_bus
    import itmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic [CNT_W-1:0]   cnt,
    input  logic [CNT_W-1:0]   latch,
    input  logic [NUM_IRQ-1:0] flags,
    input  logic [NUM_IRQ-1:0] enables,
    input  logic               irq_any,
    output logic               lat_lo_we,
    output logic               lat_hi_we,
    output logic               start,
    output logic               cnt_lo_rd,
    output logic               flag_we,
    output logic               en_we,
    output logic               free_run,
    output logic [BYTE_W-1:0]  rdata
);
    logic [BYTE_W-1:0] mode_q;
    logic              do_wr;
    logic              do_rd;

    assign do_wr = sel && wr;
    assign do_rd = sel && !wr;

    // Write and read side-effect strobes.
    always_comb begin
        lat_lo_we = do_wr && ((addr == A_CNT_LO) || (addr == A_LAT_LO));
        lat_hi_we = do_wr && (addr == A_LAT_HI);
        start     = do_wr && (addr == A_CNT_HI);
        flag_we   = do_wr && (addr == A_FLAG);
        en_we     = do_wr && (addr == A_ENAB);
        cnt_lo_rd = do_rd && (addr == A_CNT_LO);
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= '0;
        else if (do_wr && addr == A_MODE)
            mode_q <= wdata;
    end

    assign free_run = (mode_q[BYTE_W-1:BYTE_W-2] == MODE_FREE_RUN);

    // Read mux.
    always_comb begin
        case (addr)
            A_CNT_LO: rdata = cnt[BYTE_W-1:0];
            A_CNT_HI: rdata = cnt[CNT_W-1:BYTE_W];
            A_LAT_LO: rdata = latch[BYTE_W-1:0];
            A_LAT_HI: rdata = latch[CNT_W-1:BYTE_W];
            A_MODE:   rdata = mode_q;
            A_FLAG:   rdata = {irq_any, flags};
            A_ENAB:   rdata = {1'b1, enables};
            default:  rdata = '0;
        endcase
    end

    // At most one write strobe per cycle.
    p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lat_lo_we, lat_hi_we, start, flag_we, en_we}));
endmodule

// File: rtl/itmr_top.sv
// Module: itmr_top
// Interval timer top: bus decode, counter with reload latches, and the
// interrupt flag/enable registers. The flag-and-enable OR drives irq_n.
module itmr_top
    import itmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BYTE_W-1:0]  wdata,
    output logic [BYTE_W-1:0]  rdata,
    input  logic [NUM_IRQ-2:0] ext_set,
    output logic               irq_n
);
    logic               lat_lo_we, lat_hi_we, start, cnt_lo_rd, flag_we, en_we;
    logic               free_run, tick, irq_any;
    logic [CNT_W-1:0]   cnt, latch;
    logic [NUM_IRQ-1:0] flags, enables;

    itmr_bus u_bus (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
        .cnt(cnt), .latch(latch), .flags(flags), .enables(enables), .irq_any(irq_any),
        .lat_lo_we(lat_lo_we), .lat_hi_we(lat_hi_we), .start(start),
        .cnt_lo_rd(cnt_lo_rd), .flag_we(flag_we), .en_we(en_we),
        .free_run(free_run), .rdata(rdata)
    );

    itmr_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .lat_lo_we(lat_lo_we), .lat_hi_we(lat_hi_we),
        .start(start), .wdata(wdata), .free_run(free_run),
        .cnt(cnt), .latch(latch), .tick(tick)
    );

    itmr_irq u_irq (
        .clk(clk), .rst_n(rst_n), .tmr_set(tick), .tmr_clr(start || cnt_lo_rd),
        .ext_set(ext_set), .flag_we(flag_we), .en_we(en_we), .wdata(wdata),
        .flags(flags), .enables(enables), .irq_any(irq_any)
    );

    assign irq_n = ~irq_any;
endmodule

// File: tb/itmr_top_test.sv
module itmr_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel = 1'b0;
    logic       wr = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [5:0] ext_set = '0;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    itmr_top uut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata), .ext_set(ext_set), .irq_n(irq_n)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    // All bus tasks start and end at a falling edge.
    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(posedge clk); @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic t_reset;
        logic [7:0] d;
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        rd_reg(3'd5, d); chk("R1 flags", d, 8'h00);
        rd_reg(3'd6, d); chk("R1 enables", d, 8'h80);
        rd_reg(3'd4, d); chk("R1 mode", d, 8'h00);
        rd_reg(3'd1, d); chk("R1 cnt hi", d, 8'h00);
    endtask

    task automatic t_latch_only;
        logic [7:0] d;
        wr_reg(3'd0, 8'h5A);
        rd_reg(3'd0, d); chk("R2 cnt lo untouched", d, 8'h00);
        rd_reg(3'd2, d); chk("R2 latch lo", d, 8'h5A);
        wr_reg(3'd3, 8'h12);
        rd_reg(3'd3, d); chk("R11 latch hi", d, 8'h12);
        rd_reg(3'd1, d); chk("R11 cnt hi untouched", d, 8'h00);
        step(2);
        rd_reg(3'd0, d); chk("R11 counter not started", d, 8'h00);
    endtask

    task automatic t_enable;
        logic [7:0] d;
        wr_reg(3'd6, 8'h83);
        rd_reg(3'd6, d); chk("R6 set bits", d, 8'h83);
        wr_reg(3'd6, 8'h01);
        rd_reg(3'd6, d); chk("R7 clear bit0", d, 8'h82);
        wr_reg(3'd6, 8'h80);
        rd_reg(3'd6, d); chk("R6 set none", d, 8'h82);
        wr_reg(3'd6, 8'h7F);
        rd_reg(3'd6, d); chk("R7 clear all", d, 8'h80);
    endtask

    task automatic t_ext_flags;
        logic [7:0] d;
        ext_set = 6'b000100;
        @(posedge clk); @(negedge clk);
        ext_set = '0;
        chk("R9 irq_n masked", {7'd0, irq_n}, 8'h01);
        wr_reg(3'd6, 8'h84);
        chk("R9 irq_n enabled", {7'd0, irq_n}, 8'h00);
        rd_reg(3'd5, d); chk("R10 flag bit2 and R9 bit7", d, 8'h84);
        wr_reg(3'd5, 8'h04);
        chk("R10 clear irq_n", {7'd0, irq_n}, 8'h01);
        rd_reg(3'd5, d); chk("R10 flags cleared", d, 8'h00);
        wr_reg(3'd6, 8'h04);
    endtask

    task automatic t_load;
        logic [7:0] d;
        wr_reg(3'd0, 8'h34);
        wr_reg(3'd1, 8'h12);
        rd_reg(3'd1, d); chk("R3 counter hi loaded", d, 8'h12);
        rd_reg(3'd0, d); chk("R12 counter lo counting", d, 8'h33);
        rd_reg(3'd3, d); chk("R3 latch hi", d, 8'h12);
    endtask

    task automatic t_no_freerun;
        logic [7:0] d;
        wr_reg(3'd6, 8'hC0);
        wr_reg(3'd0, 8'h03);
        wr_reg(3'd1, 8'h00);
        step(6);
        rd_reg(3'd0, d); chk("R5 wraps without reload", d, 8'hFD);
        chk("R5 irq_n", {7'd0, irq_n}, 8'h01);
        rd_reg(3'd5, d); chk("R5 no flag", d, 8'h00);
    endtask

    task automatic t_freerun;
        logic [7:0] d;
        wr_reg(3'd4, 8'h40);
        rd_reg(3'd4, d); chk("R12 mode readback", d, 8'h40);
        wr_reg(3'd0, 8'h05);
        wr_reg(3'd1, 8'h00);           // start edge = k0
        step(5);
        chk("R4 no flag at k5", {7'd0, irq_n}, 8'h01);
        step(1);
        chk("R4 flag at k6", {7'd0, irq_n}, 8'h00);
        rd_reg(3'd0, d); chk("R4 counter past zero", d, 8'hFF);
        chk("R8 read lo clears", {7'd0, irq_n}, 8'h01);
        rd_reg(3'd0, d); chk("R4 reloaded", d, 8'h05);
        step(4);
        chk("R4 no flag at k12", {7'd0, irq_n}, 8'h01);
        step(1);
        chk("R4 period N+2", {7'd0, irq_n}, 8'h00);
        rd_reg(3'd5, d); chk("R9 flag read", d, 8'hC0);
        rd_reg(3'd1, d);
        chk("R8 read hi keeps flag", {7'd0, irq_n}, 8'h00);
        wr_reg(3'd1, 8'h00);
        chk("R3 start clears flag", {7'd0, irq_n}, 8'h01);
        wr_reg(3'd4, 8'h00);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_latch_only;
        t_enable;
        t_ext_flags;
        t_load;
        t_no_freerun;
        t_freerun;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule